// File: doc/BRIEF.md
# Shadow Doorbell Configuration Handler

This block services the vendor-specific admin command that sets up shadow doorbells for a storage queue controller. The command carries two guest memory bases. The first pointer field is the base of the buffer where the host writes queue pointers. The second pointer field is the base of the buffer where the controller publishes event indices. The handler rejects a base that is zero or not page-aligned. When both bases are acceptable, it writes a per-queue location pair into an internal table for every I/O submission queue and completion queue that has been created. Every command receives one completion status.

Queue creation events from the surrounding controller mark a queue as present and clear its stored locations, which turns shadowing off for that queue. Other logic reads the table through a combinational lookup port, selecting a queue id and a queue type. The whole table is written in a single clock edge. The completion appears on the cycle after the command.

Top module: `shadow_doorbell_cfg`

## Requirements
- R1: After reset, cplValid is 0, and every lookup returns doorbell address 0, event address 0 and lkEnabled 0.
- R2: Each cycle with cmdValid high produces cplValid high on the next cycle only. cplValid stays low in every other cycle.
- R3: A command whose opcode is not 0xC0 completes with status 0x4001 (invalid opcode, do-not-retry bit 14 set) and changes no table entry.
- R4: An opcode 0xC0 command completes with status 0x41C0 (invalid address, bit 14 set) and changes no table entry when either base is zero or has any of its low log2(PAGE_BYTES) bits set. The default PAGE_BYTES is 4096, so this covers bits 11..0.
- R5: An opcode 0xC0 command with two nonzero page-aligned bases completes with status 0x0000.
- R6: After an accepted command, a created submission queue i (i ≥ 1) holds doorbell address dbBase + 8·i and event address evBase + 8·i.
- R7: After an accepted command, a created completion queue i (i ≥ 1) holds doorbell address dbBase + 8·i + 4 and event address evBase + 8·i + 4.
- R8: Queue id 0 is never programmed. Its lookups always return 0 for both types.
- R9: A queue that has not been created when an accepted command completes keeps zero addresses. This includes a queue whose creation arrives in the same cycle as the command.
- R10: A creation event (qCreateIsCq 0 selects the submission queue, 1 selects the completion queue) clears both stored addresses of that queue. A later accepted command programs the queue again.
- R11: lkEnabled is 1 exactly when the selected doorbell address is nonzero. lkIsCq 0 selects the submission queue and 1 selects the completion queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Admin command present this cycle |
| cmdOpcode | input | 8 | Admin opcode |
| cmdDbBase | input | ADDR_W | First pointer field: doorbell buffer base |
| cmdEvBase | input | ADDR_W | Second pointer field: event-index buffer base |
| qCreateValid | input | 1 | A queue is being created this cycle |
| qCreateId | input | QID_W | Id of the queue being created |
| qCreateIsCq | input | 1 | 1 = completion queue, 0 = submission queue |
| cplValid | output | 1 | One-cycle completion strobe |
| cplStatus | output | 16 | Completion status word |
| lkQid | input | QID_W | Lookup queue id |
| lkIsCq | input | 1 | Lookup type select |
| lkDbAddr | output | ADDR_W | Stored doorbell address |
| lkEvAddr | output | ADDR_W | Stored event-index address |
| lkEnabled | output | 1 | Shadowing enabled for the selected queue |

## Verification
The assertions check the per-cycle rules on every cycle. These are the one-cycle completion timing, the status returned for a foreign opcode or a zero base, queue 0 staying empty, creation clearing a queue, and absent queues holding still while a command is accepted. The address arithmetic for each queue id and type can only be shown by the bench's scenarios. The same holds for rejection on every low alignment bit of each base, recreation followed by reprogramming, and a creation arriving in the same cycle as the command. The bench sweeps the complete table against values it computes itself.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
  localparam logic [7:0]  OPC_SET_SHADOW = 8'hC0;
  localparam int          DNR_BIT        = 14;
  localparam logic [15:0] DNR_MASK       = 16'(1) << DNR_BIT;
  localparam logic [15:0] STS_OK         = 16'h0000;
  localparam logic [15:0] STS_BAD_OPCODE = DNR_MASK | 16'h0001;
  localparam logic [15:0] STS_BAD_ADDR   = DNR_MASK | 16'h01C0;
  localparam int          SLOT_BYTES     = 4;

  typedef struct packed {
    logic prog;    // accepted command: load the table
    logic reject;  // command refused, table must hold
  } sdb_strobe_t;
endpackage

// File: rtl/sdb_ctrl.sv
module sdb_ctrl
  import sdb_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [7:0]        cmdOpcode,
  input  logic [ADDR_W-1:0] cmdDbBase,
  input  logic [ADDR_W-1:0] cmdEvBase,
  output sdb_strobe_t       strobe,
  output logic              cplValid,
  output logic [15:0]       cplStatus
);
  localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);

  logic        opMatch;
  logic        dbBad;
  logic        evBad;
  logic [15:0] nextStatus;

  always_comb begin
    opMatch = (cmdOpcode == OPC_SET_SHADOW);
    dbBad   = (cmdDbBase == '0) || (|cmdDbBase[PAGE_SHIFT-1:0]);
    evBad   = (cmdEvBase == '0) || (|cmdEvBase[PAGE_SHIFT-1:0]);
    if (!opMatch)            nextStatus = STS_BAD_OPCODE;
    else if (dbBad || evBad) nextStatus = STS_BAD_ADDR;
    else                     nextStatus = STS_OK;
    strobe.prog   = cmdValid && opMatch && !dbBad && !evBad;
    strobe.reject = cmdValid && !strobe.prog;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cplValid  <= 1'b0;
      cplStatus <= STS_OK;
    end else begin
      cplValid <= cmdValid;
      if (cmdValid) cplStatus <= nextStatus;
    end
  end

  AST_CPL_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> cplValid); // R2
  AST_CPL_ONLY_AFTER_CMD: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> !cplValid); // R2
  AST_FOREIGN_OPCODE: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdOpcode != OPC_SET_SHADOW |=> cplStatus == 16'h4001); // R3
  AST_ZERO_BASE: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdOpcode == OPC_SET_SHADOW && (cmdDbBase == '0 || cmdEvBase == '0)
    |=> cplStatus == 16'h41C0); // R4
endmodule

// File: rtl/sdb_table.sv
module sdb_table
  import sdb_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int NUM_QUEUES = 8,
  parameter int QID_W      = $clog2(NUM_QUEUES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  sdb_strobe_t       strobe,
  input  logic [ADDR_W-1:0] dbBase,
  input  logic [ADDR_W-1:0] evBase,
  input  logic              qCreateValid,
  input  logic [QID_W-1:0]  qCreateId,
  input  logic              qCreateIsCq,
  input  logic [QID_W-1:0]  lkQid,
  input  logic              lkIsCq,
  output logic [ADDR_W-1:0] lkDbAddr,
  output logic [ADDR_W-1:0] lkEvAddr,
  output logic              lkEnabled
);
  localparam int PAIR_STRIDE = 2 * SLOT_BYTES;

  logic [NUM_QUEUES-1:0] sqExists;
  logic [NUM_QUEUES-1:0] cqExists;
  logic [ADDR_W-1:0]     sqDb [NUM_QUEUES];
  logic [ADDR_W-1:0]     sqEv [NUM_QUEUES];
  logic [ADDR_W-1:0]     cqDb [NUM_QUEUES];
  logic [ADDR_W-1:0]     cqEv [NUM_QUEUES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sqExists <= '0;
      cqExists <= '0;
      for (int i = 0; i < NUM_QUEUES; i++) begin
        sqDb[i] <= '0;
        sqEv[i] <= '0;
        cqDb[i] <= '0;
        cqEv[i] <= '0;
      end
    end else begin
      for (int i = 1; i < NUM_QUEUES; i++) begin
        if (strobe.prog && sqExists[i]) begin
          sqDb[i] <= dbBase + ADDR_W'(i * PAIR_STRIDE);
          sqEv[i] <= evBase + ADDR_W'(i * PAIR_STRIDE);
        end
        if (strobe.prog && cqExists[i]) begin
          cqDb[i] <= dbBase + ADDR_W'(i * PAIR_STRIDE + SLOT_BYTES);
          cqEv[i] <= evBase + ADDR_W'(i * PAIR_STRIDE + SLOT_BYTES);
        end
      end
      if (qCreateValid) begin
        if (qCreateIsCq) begin
          cqExists[qCreateId] <= 1'b1;
          cqDb[qCreateId]     <= '0;
          cqEv[qCreateId]     <= '0;
        end else begin
          sqExists[qCreateId] <= 1'b1;
          sqDb[qCreateId]     <= '0;
          sqEv[qCreateId]     <= '0;
        end
      end
    end
  end

  always_comb begin
    lkDbAddr  = lkIsCq ? cqDb[lkQid] : sqDb[lkQid];
    lkEvAddr  = lkIsCq ? cqEv[lkQid] : sqEv[lkQid];
    lkEnabled = (lkDbAddr != '0);
  end

  AST_CREATE_CLEARS_SQ: assert property (@(posedge clk) disable iff (!rstN)
    qCreateValid && !qCreateIsCq |=> sqDb[$past(qCreateId)] == '0 && sqEv[$past(qCreateId)] == '0); // R10
  AST_CREATE_CLEARS_CQ: assert property (@(posedge clk) disable iff (!rstN)
    qCreateValid && qCreateIsCq |=> cqDb[$past(qCreateId)] == '0 && cqEv[$past(qCreateId)] == '0); // R10

  for (genvar g = 0; g < NUM_QUEUES; g++) begin : g_chk
    AST_ABSENT_SQ_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      strobe.prog && !sqExists[g] |=> sqDb[g] == '0); // R9
    AST_ABSENT_CQ_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      strobe.prog && !cqExists[g] |=> cqDb[g] == '0); // R9
    AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      strobe.reject && !qCreateValid |=> sqDb[g] == $past(sqDb[g]) && cqEv[g] == $past(cqEv[g])); // R4
  end
endmodule

// File: rtl/shadow_doorbell_cfg.sv
module shadow_doorbell_cfg
  import sdb_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int NUM_QUEUES = 8,
  parameter int PAGE_BYTES = 4096,
  parameter int QID_W      = $clog2(NUM_QUEUES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [7:0]        cmdOpcode,
  input  logic [ADDR_W-1:0] cmdDbBase,
  input  logic [ADDR_W-1:0] cmdEvBase,
  input  logic              qCreateValid,
  input  logic [QID_W-1:0]  qCreateId,
  input  logic              qCreateIsCq,
  output logic              cplValid,
  output logic [15:0]       cplStatus,
  input  logic [QID_W-1:0]  lkQid,
  input  logic              lkIsCq,
  output logic [ADDR_W-1:0] lkDbAddr,
  output logic [ADDR_W-1:0] lkEvAddr,
  output logic              lkEnabled
);
  sdb_strobe_t strobe;

  sdb_ctrl #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdOpcode (cmdOpcode),
    .cmdDbBase (cmdDbBase),
    .cmdEvBase (cmdEvBase),
    .strobe    (strobe),
    .cplValid  (cplValid),
    .cplStatus (cplStatus)
  );

  sdb_table #(.ADDR_W(ADDR_W), .NUM_QUEUES(NUM_QUEUES), .QID_W(QID_W)) i_table (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .dbBase       (cmdDbBase),
    .evBase       (cmdEvBase),
    .qCreateValid (qCreateValid),
    .qCreateId    (qCreateId),
    .qCreateIsCq  (qCreateIsCq),
    .lkQid        (lkQid),
    .lkIsCq       (lkIsCq),
    .lkDbAddr     (lkDbAddr),
    .lkEvAddr     (lkEvAddr),
    .lkEnabled    (lkEnabled)
  );

  AST_ADMIN_PAIR_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    lkQid == '0 |-> lkDbAddr == '0 && lkEvAddr == '0 && !lkEnabled); // R8
  AST_ENABLE_MATCHES: assert property (@(posedge clk) disable iff (!rstN)
    lkEnabled == (lkDbAddr != '0)); // R11
endmodule

// File: tb/test_shadow_doorbell_cfg.sv
module test_shadow_doorbell_cfg;
  localparam int NQ = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [7:0]  cmdOpcode = '0;
  logic [63:0] cmdDbBase = '0;
  logic [63:0] cmdEvBase = '0;
  logic        qCreateValid = 1'b0;
  logic [2:0]  qCreateId = '0;
  logic        qCreateIsCq = 1'b0;
  logic        cplValid;
  logic [15:0] cplStatus;
  logic [2:0]  lkQid = '0;
  logic        lkIsCq = 1'b0;
  logic [63:0] lkDbAddr;
  logic [63:0] lkEvAddr;
  logic        lkEnabled;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  logic [63:0] mDb [2][NQ];
  logic [63:0] mEv [2][NQ];
  bit          mEx [2][NQ];

  always #5 clk = ~clk;

  shadow_doorbell_cfg i_shadow_doorbell_cfg (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOpcode(cmdOpcode),
    .cmdDbBase(cmdDbBase), .cmdEvBase(cmdEvBase), .qCreateValid(qCreateValid),
    .qCreateId(qCreateId), .qCreateIsCq(qCreateIsCq), .cplValid(cplValid),
    .cplStatus(cplStatus), .lkQid(lkQid), .lkIsCq(lkIsCq), .lkDbAddr(lkDbAddr),
    .lkEvAddr(lkEvAddr), .lkEnabled(lkEnabled)
  );

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sweepTable(string tag);
    for (int t = 0; t < 2; t++) begin
      for (int q = 0; q < NQ; q++) begin
        string req;
        lkIsCq = t[0];
        lkQid  = 3'(q);
        #1;
        if (tag != "") req = tag;
        else if (q == 0) req = "R8";
        else if (!mEx[t][q]) req = "R9";
        else req = (t == 1) ? "R7" : "R6";
        check(lkDbAddr == mDb[t][q], {req, " db"}, lkDbAddr, mDb[t][q]);
        check(lkEvAddr == mEv[t][q], {req, " ev"}, lkEvAddr, mEv[t][q]);
        check(lkEnabled == (mDb[t][q] != 0), "R11 enabled", 64'(lkEnabled), 64'(mDb[t][q] != 0));
      end
    end
  endtask

  task automatic createQ(int id, bit isCq);
    @(negedge clk);
    qCreateValid = 1'b1; qCreateId = 3'(id); qCreateIsCq = isCq;
    @(negedge clk);
    qCreateValid = 1'b0;
    mEx[isCq][id] = 1; mDb[isCq][id] = 0; mEv[isCq][id] = 0;
  endtask

  // Issue a command, optionally with a creation event in the same cycle.
  task automatic issue(logic [7:0] op, logic [63:0] b0, logic [63:0] b1,
                       logic [15:0] expSt, string req, int cId, bit cCq, bit withCreate);
    @(negedge clk);
    cmdValid = 1'b1; cmdOpcode = op; cmdDbBase = b0; cmdEvBase = b1;
    if (withCreate) begin
      qCreateValid = 1'b1; qCreateId = 3'(cId); qCreateIsCq = cCq;
    end
    @(negedge clk);
    cmdValid = 1'b0; qCreateValid = 1'b0;
    check(cplValid == 1'b1, "R2 pulse", 64'(cplValid), 64'd1);
    check(cplStatus == expSt, req, 64'(cplStatus), 64'(expSt));
    if (expSt == 16'h0000) begin
      for (int t = 0; t < 2; t++)
        for (int q = 1; q < NQ; q++)
          if (mEx[t][q]) begin
            mDb[t][q] = b0 + 64'(8 * q + 4 * t);
            mEv[t][q] = b1 + 64'(8 * q + 4 * t);
          end
    end
    if (withCreate) begin
      mEx[cCq][cId] = 1; mDb[cCq][cId] = 0; mEv[cCq][cId] = 0;
    end
    @(negedge clk);
    check(cplValid == 1'b0, "R2 single", 64'(cplValid), 64'd0);
  endtask

  initial begin
    for (int t = 0; t < 2; t++)
      for (int q = 0; q < NQ; q++) begin
        mDb[t][q] = 0; mEv[t][q] = 0; mEx[t][q] = 0;
      end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(cplValid == 1'b0, "R1 cplValid", 64'(cplValid), 64'd0);
    sweepTable("R1");

    // Command before any queue exists: accepted, nothing programmed (R9)
    issue(8'hC0, 64'h1000_0000, 64'h2000_0000, 16'h0000, "R5 status", 0, 0, 0);
    sweepTable("R9");

    createQ(0, 0); createQ(0, 1);
    createQ(1, 0); createQ(2, 0); createQ(3, 0); createQ(5, 0); createQ(7, 0);
    createQ(1, 1); createQ(2, 1); createQ(4, 1); createQ(7, 1);
    issue(8'hC0, 64'h0000_0001_0000_0000, 64'h0000_0002_0000_3000, 16'h0000, "R5 status", 0, 0, 0);
    sweepTable("");

    // R3 every foreign opcode refused, table unchanged
    for (int op = 0; op < 256; op++)
      if (op != 8'hC0)
        issue(8'(op), 64'h5000, 64'h6000, 16'h4001, "R3 status", 0, 0, 0);
    sweepTable("R3");

    // R4 zero bases and every low alignment bit of each base
    issue(8'hC0, 64'h0, 64'h8000, 16'h41C0, "R4 zero db", 0, 0, 0);
    issue(8'hC0, 64'h8000, 64'h0, 16'h41C0, "R4 zero ev", 0, 0, 0);
    issue(8'hC0, 64'h0, 64'h0, 16'h41C0, "R4 both zero", 0, 0, 0);
    for (int b = 0; b < 12; b++) begin
      issue(8'hC0, 64'h9000 | (64'd1 << b), 64'hA000, 16'h41C0, "R4 db align", 0, 0, 0);
      issue(8'hC0, 64'h9000, 64'hA000 | (64'd1 << b), 16'h41C0, "R4 ev align", 0, 0, 0);
    end
    sweepTable("R4");

    // R10 recreation clears, others unchanged
    createQ(2, 0);
    createQ(7, 1);
    sweepTable("R10");
    issue(8'hC0, 64'hFFFF_F000, 64'h1_0000, 16'h0000, "R5 status", 0, 0, 0);
    sweepTable("R10");

    // R9 creation in the same cycle as the command stays empty
    issue(8'hC0, 64'h7000_0000, 64'h7100_0000, 16'h0000, "R9 status", 3, 1, 1);
    sweepTable("");
    issue(8'hC0, 64'hABC0_0000, 64'hDEF0_0000, 16'h0000, "R5 status", 6, 0, 1);
    sweepTable("");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule